// File: doc/BRIEF.md
# DW Request to AXI-Lite Splitter

This block takes one register request from a host-facing front end and plays it out as a run of single-DW AXI-Lite transfers on a 32-bit requester port. A request names a byte address, a count of 32-bit words (1 to 16), a byte-enable mask for the first word and a byte-enable mask for the final word. Each word becomes one AXI-Lite transfer with its own address and strobe. The first transfer keeps any unaligned low address bits. Every later transfer sits on a DW boundary, stepping by four bytes.

Writes drive the AW and W channels together and wait for B. Reads drive AR and wait for R. Only one transfer is ever outstanding. Read words are gathered in DW order into a wide return vector. When the last response arrives, the block raises a single completion pulse that carries an error flag. The flag is set if any transfer in the request came back with a response other than OKAY.

Top module: `dw_lite_splitter`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after acceptance until the completion pulse has been given.
- R2: An accepted request with `req_dw_cnt` = N (1 ≤ N ≤ 16) produces exactly N transfers. Write transfer k carries `req_wdata[32k+31:32k]` as its data.
- R3: Transfer 0 uses `req_addr` unchanged, including bits [1:0], and uses `req_first_be` as its strobe. Example: address 0x1 with enables 4'b1110 gives address 0x1 and strobe 0xE.
- R4: Transfer k > 0 uses `req_addr` with bits [1:0] cleared, plus 4·k. Example: 3 DW from 0x1 gives addresses 0x1, 0x4, 0x8.
- R5: When N ≥ 2, the last transfer uses `req_last_be` as its strobe and every transfer between the first and the last uses 0xF. An aligned 2-DW request with all enables set gives 0x0/0xF then 0x4/0xF.
- R6: When N = 1, the single transfer uses `req_first_be` as its strobe and `req_last_be` has no effect.
- R7: Reads use the same address sequence on AR as writes use on AW. The R data of transfer k appears in `cpl_rdata[32k+31:32k]`. Lanes at k ≥ N read as zero.
- R8: `cpl_error` is 1 at completion exactly when at least one B or R response in the request had a response code other than OKAY (2'b00). A failing transfer does not stop the remaining transfers.
- R9: `cpl_valid` is a one-cycle pulse, given in the cycle after the last response is accepted. A write completion returns `cpl_rdata` all zero.
- R10: No AW, W or AR valid is presented while a B or R response is still awaited. AW and W of a write transfer are offered from the same cycle.
- R11: Once `m_awvalid`, `m_wvalid` or `m_arvalid` is high, it stays high with stable address, data and strobe until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_dw_cnt | input | CNT_W | Number of DWs, 1 to MAX_DW |
| req_first_be | input | 4 | Byte enables of the first DW |
| req_last_be | input | 4 | Byte enables of the last DW |
| req_wdata | input | 32·MAX_DW | Write data, DW k in bits [32k+31:32k] |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_error | output | 1 | Some transfer returned a non-OKAY response |
| cpl_rdata | output | 32·MAX_DW | Read data packed in DW order |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write address |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write strobe |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Read address |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response code |

## Verification
The properties assume three things about the inputs. The front end only offers word counts from 1 to MAX_DW. It holds the request fields steady while `req_valid` is high. The AXI-Lite completer raises B or R only after taking the matching address.

The directed stimulus keeps to these assumptions. It uses counts of 1, 2, 3, 4 and 16. It drops `req_valid` right after the accepting edge. It drives a responder that grants AW and W together after a programmable stall and returns one response per accepted address. Because the error-injection point and the stall length are set per scenario, the error flag and the hold-until-ready rules are exercised under back-pressure.

// File: rtl/dwl_pkg.sv
package dwl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ISSUE  = 3'd1,
    ST_WAIT_B = 3'd2,
    ST_WAIT_R = 3'd3,
    ST_DONE   = 3'd4
  } dwl_state_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;
  localparam int         DW_BITS   = 32;
  localparam int         BE_BITS   = 4;

endpackage

// File: rtl/dwl_addr_gen.sv
// Per-beat address and strobe: beat 0 keeps the raw byte address and the
// first-word enables; later beats are DW aligned and step by 4 bytes.
module dwl_addr_gen
  import dwl_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int MAX_DW = 16,
  localparam int IDX_W  = $clog2(MAX_DW),
  localparam int CNT_W  = $clog2(MAX_DW + 1)
) (
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic [IDX_W-1:0]   beat_idx,
  input  logic [CNT_W-1:0]   dw_cnt,
  input  logic [BE_BITS-1:0] first_be,
  input  logic [BE_BITS-1:0] last_be,
  output logic [ADDR_W-1:0]  beat_addr,
  output logic [BE_BITS-1:0] beat_strb
);

  logic              is_first;
  logic              is_final;
  logic [ADDR_W-1:0] aligned_base;
  logic [ADDR_W-1:0] step_offset;

  always_comb begin
    is_first     = (beat_idx == '0);
    is_final     = ((CNT_W'(beat_idx) + CNT_W'(1)) == dw_cnt);
    aligned_base = {base_addr[ADDR_W-1:2], 2'b00};
    step_offset  = ADDR_W'(beat_idx) << 2;

    if (is_first) begin
      beat_addr = base_addr;
    end else begin
      beat_addr = aligned_base + step_offset;
    end

    if (is_first) begin
      beat_strb = first_be;
    end else if (is_final) begin
      beat_strb = last_be;
    end else begin
      beat_strb = {BE_BITS{1'b1}};
    end
  end

endmodule

// File: rtl/dwl_seq.sv
// Transfer sequencer: one AXI-Lite transfer in flight at a time.
module dwl_seq
  import dwl_pkg::*;
#(
  parameter  int MAX_DW = 16,
  localparam int IDX_W  = $clog2(MAX_DW),
  localparam int CNT_W  = $clog2(MAX_DW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic [CNT_W-1:0] dw_cnt,
  input  logic             awready,
  input  logic             wready,
  input  logic             bvalid,
  input  logic [1:0]       bresp,
  input  logic             arready,
  input  logic             rvalid,
  input  logic [1:0]       rresp,
  output logic             idle,
  output logic             awvalid,
  output logic             wvalid,
  output logic             arvalid,
  output logic             bready,
  output logic             rready,
  output logic             capture,
  output logic             cpl_valid,
  output logic             cpl_error,
  output logic [IDX_W-1:0] beat_idx
);

  dwl_state_e       state_q, state_d;
  logic [IDX_W-1:0] beat_q, beat_d;
  logic             aw_done_q, aw_done_d;
  logic             w_done_q, w_done_d;
  logic             err_q, err_d;
  logic             last_beat;
  logic             beat_en;
  logic             flag_en;

  // outputs decoded from registered state
  always_comb begin
    idle      = (state_q == ST_IDLE);
    awvalid   = (state_q == ST_ISSUE) && is_write && !aw_done_q;
    wvalid    = (state_q == ST_ISSUE) && is_write && !w_done_q;
    arvalid   = (state_q == ST_ISSUE) && !is_write;
    bready    = (state_q == ST_WAIT_B);
    rready    = (state_q == ST_WAIT_R);
    capture   = rready && rvalid;
    cpl_valid = (state_q == ST_DONE);
    cpl_error = (state_q == ST_DONE) && err_q;
    beat_idx  = beat_q;
    last_beat = ((CNT_W'(beat_q) + CNT_W'(1)) == dw_cnt);
  end

  // next-state logic
  always_comb begin
    logic aw_now;
    logic w_now;
    state_d   = state_q;
    beat_d    = beat_q;
    aw_done_d = aw_done_q;
    w_done_d  = w_done_q;
    err_d     = err_q;
    aw_now    = aw_done_q || (awvalid && awready);
    w_now     = w_done_q || (wvalid && wready);
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d   = ST_ISSUE;
          beat_d    = '0;
          err_d     = 1'b0;
          aw_done_d = 1'b0;
          w_done_d  = 1'b0;
        end
      end
      ST_ISSUE: begin
        if (is_write) begin
          if (aw_now && w_now) begin
            state_d   = ST_WAIT_B;
            aw_done_d = 1'b0;
            w_done_d  = 1'b0;
          end else begin
            aw_done_d = aw_now;
            w_done_d  = w_now;
          end
        end else if (arready) begin
          state_d = ST_WAIT_R;
        end
      end
      ST_WAIT_B: begin
        if (bvalid) begin
          err_d = err_q || (bresp != RESP_OKAY);
          if (last_beat) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_ISSUE;
            beat_d  = beat_q + IDX_W'(1);
          end
        end
      end
      ST_WAIT_R: begin
        if (rvalid) begin
          err_d = err_q || (rresp != RESP_OKAY);
          if (last_beat) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_ISSUE;
            beat_d  = beat_q + IDX_W'(1);
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    beat_en = (beat_d != beat_q) || (state_q == ST_IDLE);
    flag_en = (state_q != ST_DONE);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_done_q <= 1'b0;
      w_done_q  <= 1'b0;
      err_q     <= 1'b0;
    end else if (flag_en) begin
      aw_done_q <= aw_done_d;
      w_done_q  <= w_done_d;
      err_q     <= err_d;
    end
  end

endmodule

// File: rtl/dwl_rd_buf.sv
// Read return buffer: one 32-bit lane per DW, cleared when a request starts.
module dwl_rd_buf
  import dwl_pkg::*;
#(
  parameter  int MAX_DW = 16,
  localparam int IDX_W  = $clog2(MAX_DW)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      capture,
  input  logic [IDX_W-1:0]          idx,
  input  logic [DW_BITS-1:0]        data,
  output logic [MAX_DW*DW_BITS-1:0] lanes
);

  for (genvar i = 0; i < MAX_DW; i++) begin : g_lane
    logic [DW_BITS-1:0] lane_q;
    logic [DW_BITS-1:0] lane_d;
    logic               lane_en;

    always_comb begin
      lane_en = clear || (capture && (idx == IDX_W'(i)));
      lane_d  = clear ? '0 : data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (lane_en) begin
        lane_q <= lane_d;
      end
    end

    assign lanes[DW_BITS*i +: DW_BITS] = lane_q;
  end

endmodule

// File: rtl/dw_lite_splitter.sv
module dw_lite_splitter
  import dwl_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int MAX_DW = 16,
  localparam int IDX_W  = $clog2(MAX_DW),
  localparam int CNT_W  = $clog2(MAX_DW + 1),
  localparam int BUF_W  = MAX_DW * DW_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [CNT_W-1:0]   req_dw_cnt,
  input  logic [3:0]         req_first_be,
  input  logic [3:0]         req_last_be,
  input  logic [BUF_W-1:0]   req_wdata,
  output logic               cpl_valid,
  output logic               cpl_error,
  output logic [BUF_W-1:0]   cpl_rdata,
  output logic               m_awvalid,
  input  logic               m_awready,
  output logic [ADDR_W-1:0]  m_awaddr,
  output logic               m_wvalid,
  input  logic               m_wready,
  output logic [31:0]        m_wdata,
  output logic [3:0]         m_wstrb,
  input  logic               m_bvalid,
  output logic               m_bready,
  input  logic [1:0]         m_bresp,
  output logic               m_arvalid,
  input  logic               m_arready,
  output logic [ADDR_W-1:0]  m_araddr,
  input  logic               m_rvalid,
  output logic               m_rready,
  input  logic [31:0]        m_rdata,
  input  logic [1:0]         m_rresp
);

  logic               accept;
  logic               idle;
  logic               capture;
  logic [IDX_W-1:0]   beat_idx;
  logic [ADDR_W-1:0]  beat_addr;
  logic [BE_BITS-1:0] beat_strb;

  logic               wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [3:0]         fbe_q;
  logic [3:0]         lbe_q;
  logic [BUF_W-1:0]   wdata_q;

  assign req_ready = idle;
  assign accept    = req_valid && idle;

  // request holding registers, loaded on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
      fbe_q   <= '0;
      lbe_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      cnt_q   <= req_dw_cnt;
      fbe_q   <= req_first_be;
      lbe_q   <= req_last_be;
      wdata_q <= req_wdata;
    end
  end

  dwl_seq #(.MAX_DW(MAX_DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .is_write  (wr_q),
    .dw_cnt    (cnt_q),
    .awready   (m_awready),
    .wready    (m_wready),
    .bvalid    (m_bvalid),
    .bresp     (m_bresp),
    .arready   (m_arready),
    .rvalid    (m_rvalid),
    .rresp     (m_rresp),
    .idle      (idle),
    .awvalid   (m_awvalid),
    .wvalid    (m_wvalid),
    .arvalid   (m_arvalid),
    .bready    (m_bready),
    .rready    (m_rready),
    .capture   (capture),
    .cpl_valid (cpl_valid),
    .cpl_error (cpl_error),
    .beat_idx  (beat_idx)
  );

  dwl_addr_gen #(.ADDR_W(ADDR_W), .MAX_DW(MAX_DW)) u_addr (
    .base_addr (addr_q),
    .beat_idx  (beat_idx),
    .dw_cnt    (cnt_q),
    .first_be  (fbe_q),
    .last_be   (lbe_q),
    .beat_addr (beat_addr),
    .beat_strb (beat_strb)
  );

  dwl_rd_buf #(.MAX_DW(MAX_DW)) u_rbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .capture (capture),
    .idx     (beat_idx),
    .data    (m_rdata),
    .lanes   (cpl_rdata)
  );

  assign m_awaddr = beat_addr;
  assign m_araddr = beat_addr;
  assign m_wstrb  = beat_strb;
  assign m_wdata  = wdata_q[DW_BITS*int'(beat_idx) +: DW_BITS];

endmodule

// File: rtl/dwl_checker.sv
module dwl_checker #(
  parameter  int ADDR_W = 32,
  parameter  int MAX_DW = 16,
  localparam int CNT_W  = $clog2(MAX_DW + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [CNT_W-1:0]  req_dw_cnt,
  input logic [3:0]        req_first_be,
  input logic              cpl_valid,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic [31:0]       m_wdata,
  input logic [3:0]        m_wstrb,
  input logic              m_bvalid,
  input logic              m_bready,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic [ADDR_W-1:0] m_araddr,
  input logic              m_rready
);

  // input assumption: legal word count whenever a request is offered
  p_req_cnt_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_dw_cnt >= CNT_W'(1)) && (req_dw_cnt <= CNT_W'(MAX_DW)));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(m_awvalid || m_wvalid || m_arvalid || m_bready || m_rready || cpl_valid));

  p_first_write_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=>
      (m_awvalid && m_wvalid && m_awaddr == $past(req_addr) && m_wstrb == $past(req_first_be)));

  p_first_read_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> (m_arvalid && m_araddr == $past(req_addr)));

  p_later_beat_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_bvalid && m_bready) |=> (!m_awvalid || m_awaddr[1:0] == 2'b00));

  p_single_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_bready || m_rready) |-> !(m_awvalid || m_wvalid || m_arvalid));

  p_aw_w_together_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_awvalid) |-> $rose(m_wvalid));

  p_aw_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

  p_w_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wstrb)));

  p_ar_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

  p_cpl_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> (!cpl_valid && req_ready));

endmodule

bind dw_lite_splitter dwl_checker #(.ADDR_W(ADDR_W), .MAX_DW(MAX_DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .req_dw_cnt   (req_dw_cnt),
  .req_first_be (req_first_be),
  .cpl_valid    (cpl_valid),
  .m_awvalid    (m_awvalid),
  .m_awready    (m_awready),
  .m_awaddr     (m_awaddr),
  .m_wvalid     (m_wvalid),
  .m_wready     (m_wready),
  .m_wdata      (m_wdata),
  .m_wstrb      (m_wstrb),
  .m_bvalid     (m_bvalid),
  .m_bready     (m_bready),
  .m_arvalid    (m_arvalid),
  .m_arready    (m_arready),
  .m_araddr     (m_araddr),
  .m_rready     (m_rready)
);

// File: tb/dw_lite_splitter_bench.sv
`timescale 1ns/1ps
module dw_lite_splitter_bench;

  localparam int ADDR_W = 32;
  localparam int MAX_DW = 16;
  localparam int CNT_W  = 5;
  localparam int BUF_W  = MAX_DW * 32;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic              req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [CNT_W-1:0]  req_dw_cnt;
  logic [3:0]        req_first_be;
  logic [3:0]        req_last_be;
  logic [BUF_W-1:0]  req_wdata;
  logic              cpl_valid;
  logic              cpl_error;
  logic [BUF_W-1:0]  cpl_rdata;
  logic              m_awvalid, m_awready;
  logic [ADDR_W-1:0] m_awaddr;
  logic              m_wvalid, m_wready;
  logic [31:0]       m_wdata;
  logic [3:0]        m_wstrb;
  logic              m_bvalid, m_bready;
  logic [1:0]        m_bresp;
  logic              m_arvalid, m_arready;
  logic [ADDR_W-1:0] m_araddr;
  logic              m_rvalid, m_rready;
  logic [31:0]       m_rdata;
  logic [1:0]        m_rresp;

  dw_lite_splitter #(.ADDR_W(ADDR_W), .MAX_DW(MAX_DW)) u_dw_lite_splitter (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  // responder state and transfer log
  int          stall_cyc = 0;
  int          err_beat  = -1;
  int          n_log     = 0;
  int          overlap   = 0;
  logic [31:0] log_addr [0:63];
  logic [3:0]  log_strb [0:63];
  logic [31:0] log_data [0:63];
  bit          log_wr   [0:63];

  // results captured at completion
  logic             got_err;
  logic [BUF_W-1:0] got_rd;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] a, input int k);
    return (k == 0) ? a : ((a & 32'hFFFF_FFFC) + 32'(4 * k));
  endfunction

  function automatic logic [3:0] exp_strb(input logic [3:0] f, input logic [3:0] l,
                                          input int cnt, input int k);
    if (k == 0) return f;
    if (k == cnt - 1) return l;
    return 4'hF;
  endfunction

  function automatic logic [31:0] rd_pat(input logic [31:0] a);
    return a ^ 32'h5EED_0000;
  endfunction

  function automatic logic [31:0] wr_pat(input logic [31:0] a, input int k);
    return 32'hC000_0000 + (a << 4) + 32'(k);
  endfunction

  // AXI-Lite responder: decisions at the falling edge, handshakes judged from
  // the values that were present at the preceding rising edge.
  initial begin
    bit p_awv, p_awr, p_wv, p_wr, p_arv, p_arr, p_bv, p_br, p_rv, p_rr;
    logic [31:0] p_awaddr, p_wdata, p_araddr;
    logic [3:0]  p_wstrb;
    int          wait_cnt;
    m_awready = 0; m_wready = 0; m_arready = 0;
    m_bvalid = 0; m_bresp = 0; m_rvalid = 0; m_rresp = 0; m_rdata = 0;
    p_awv = 0; p_awr = 0; p_wv = 0; p_wr = 0; p_arv = 0; p_arr = 0;
    p_bv = 0; p_br = 0; p_rv = 0; p_rr = 0;
    p_awaddr = 0; p_wdata = 0; p_araddr = 0; p_wstrb = 0; wait_cnt = 0;
    forever begin
      @(negedge clk);
      m_awready = 0; m_wready = 0; m_arready = 0;
      if (p_bv && p_br) m_bvalid = 0;
      if (p_rv && p_rr) m_rvalid = 0;
      if ((m_awvalid || m_wvalid || m_arvalid) && (m_bvalid || m_rvalid)) overlap++;
      if (p_awv && p_awr && p_wv && p_wr) begin
        log_addr[n_log] = p_awaddr; log_strb[n_log] = p_wstrb;
        log_data[n_log] = p_wdata;  log_wr[n_log] = 1;
        m_bvalid = 1; m_bresp = (n_log == err_beat) ? 2'b10 : 2'b00;
        n_log++;
      end
      if (p_arv && p_arr) begin
        log_addr[n_log] = p_araddr; log_strb[n_log] = 4'h0;
        log_data[n_log] = 0;        log_wr[n_log] = 0;
        m_rvalid = 1; m_rdata = rd_pat(p_araddr);
        m_rresp = (n_log == err_beat) ? 2'b10 : 2'b00;
        n_log++;
      end
      if ((m_awvalid && m_wvalid) || m_arvalid) begin
        if (wait_cnt >= stall_cyc) begin
          m_awready = m_awvalid && m_wvalid;
          m_wready  = m_awvalid && m_wvalid;
          m_arready = m_arvalid;
          wait_cnt  = 0;
        end else begin
          wait_cnt++;
        end
      end
      p_awv = m_awvalid; p_awr = m_awready; p_wv = m_wvalid; p_wr = m_wready;
      p_arv = m_arvalid; p_arr = m_arready; p_bv = m_bvalid; p_br = m_bready;
      p_rv = m_rvalid; p_rr = m_rready;
      p_awaddr = m_awaddr; p_wdata = m_wdata; p_wstrb = m_wstrb; p_araddr = m_araddr;
    end
  end

  task automatic run_req(input bit wr, input logic [31:0] a, input int cnt,
                         input logic [3:0] fbe, input logic [3:0] lbe,
                         input int stall, input int errb);
    int guard;
    stall_cyc = stall; err_beat = errb; n_log = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_dw_cnt = CNT_W'(cnt);
    req_first_be = fbe; req_last_be = lbe;
    for (int k = 0; k < MAX_DW; k++) req_wdata[32*k +: 32] = wr_pat(a, k);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, "R1", "busy after accept", req_ready, 0);
    guard = 0;
    while (!cpl_valid && guard < 2000) begin @(negedge clk); guard++; end
    got_err = cpl_error; got_rd = cpl_rdata;
    chk(cpl_valid == 1'b1, "R9", "completion seen", cpl_valid, 1);
    @(negedge clk);
    chk(cpl_valid == 1'b0 && req_ready == 1'b1, "R9", "single pulse then idle",
        {cpl_valid, req_ready}, 2'b01);
  endtask

  task automatic check_xfers(input bit wr, input logic [31:0] a, input int cnt,
                             input logic [3:0] fbe, input logic [3:0] lbe, input string rq);
    chk(n_log == cnt, "R2", "transfer count", n_log, cnt);
    for (int k = 0; k < cnt && k < n_log; k++) begin
      chk(log_addr[k] == exp_addr(a, k), rq, $sformatf("addr of beat %0d", k),
          log_addr[k], exp_addr(a, k));
      chk(log_wr[k] == wr, "R7", $sformatf("direction of beat %0d", k), log_wr[k], wr);
      if (wr) begin
        chk(log_strb[k] == exp_strb(fbe, lbe, cnt, k), rq, $sformatf("strobe of beat %0d", k),
            log_strb[k], exp_strb(fbe, lbe, cnt, k));
        chk(log_data[k] == wr_pat(a, k), "R2", $sformatf("data of beat %0d", k),
            log_data[k], wr_pat(a, k));
      end
    end
  endtask

  task automatic t_reset_state;
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(!m_awvalid && !m_wvalid && !m_arvalid, "R1", "no valid after reset",
        {m_awvalid, m_wvalid, m_arvalid}, 0);
    chk(cpl_valid == 1'b0 && cpl_rdata == '0, "R9", "no completion after reset",
        cpl_valid, 0);
  endtask

  task automatic t_aligned_pair;   // R5: 0x0/F then 0x4/F
    run_req(1, 32'h0, 2, 4'hF, 4'hF, 0, -1);
    check_xfers(1, 32'h0, 2, 4'hF, 4'hF, "R5");
    chk(log_addr[1] == 32'h4 && log_strb[1] == 4'hF, "R5", "aligned pair second beat",
        {log_addr[1], log_strb[1]}, {32'h4, 4'hF});
    chk(got_err == 1'b0, "R8", "no error on OKAY", got_err, 0);
  endtask

  task automatic t_unaligned_three;  // R3/R4: 0x1/E, 0x4/F, 0x8/1
    run_req(1, 32'h1, 3, 4'hE, 4'h1, 2, -1);
    check_xfers(1, 32'h1, 3, 4'hE, 4'h1, "R4");
    chk(log_addr[0] == 32'h1 && log_strb[0] == 4'hE, "R3", "first beat keeps low bits",
        {log_addr[0], log_strb[0]}, {32'h1, 4'hE});
    chk(log_addr[2] == 32'h8 && log_strb[2] == 4'h1, "R5", "last beat uses last enables",
        {log_addr[2], log_strb[2]}, {32'h8, 4'h1});
  endtask

  task automatic t_single_word;    // R6: last enables ignored
    run_req(1, 32'h0000_0232, 1, 4'h6, 4'h9, 1, -1);
    chk(n_log == 1, "R6", "one transfer", n_log, 1);
    chk(log_addr[0] == 32'h232 && log_strb[0] == 4'h6, "R6", "single beat strobe",
        {log_addr[0], log_strb[0]}, {32'h232, 4'h6});
    chk(got_rd == '0, "R9", "write completion data zero", got_rd[63:0], 0);
  endtask

  task automatic t_read_error;     // R8: error on beat 1 of 4, all beats still run
    run_req(0, 32'h200, 4, 4'hF, 4'hF, 1, 1);
    chk(n_log == 4, "R8", "beats after error", n_log, 4);
    chk(got_err == 1'b1, "R8", "error flag", got_err, 1);
    for (int k = 0; k < 4; k++)
      chk(got_rd[32*k +: 32] == rd_pat(exp_addr(32'h200, k)), "R7",
          $sformatf("read lane %0d", k), got_rd[32*k +: 32], rd_pat(exp_addr(32'h200, k)));
  endtask

  task automatic t_read_unaligned; // R7: same addressing, unused lanes zero
    run_req(0, 32'h101, 3, 4'hE, 4'h1, 0, -1);
    check_xfers(0, 32'h101, 3, 4'hE, 4'h1, "R7");
    for (int k = 0; k < 3; k++)
      chk(got_rd[32*k +: 32] == rd_pat(exp_addr(32'h101, k)), "R7",
          $sformatf("read lane %0d", k), got_rd[32*k +: 32], rd_pat(exp_addr(32'h101, k)));
    chk(got_rd[BUF_W-1:96] == '0, "R7", "lanes past count zero", got_rd[127:96], 0);
    chk(got_err == 1'b0, "R8", "error cleared for new request", got_err, 0);
  endtask

  task automatic t_full_burst;     // R2: maximum count with stalls
    run_req(1, 32'h1002, 16, 4'hC, 4'h3, 3, -1);
    check_xfers(1, 32'h1002, 16, 4'hC, 4'h3, "R4");
    chk(log_addr[15] == 32'h103C && log_strb[15] == 4'h3, "R5", "sixteenth beat",
        {log_addr[15], log_strb[15]}, {32'h103C, 4'h3});
  endtask

  task automatic t_write_error_last; // R8: error on final write beat
    run_req(1, 32'h40, 2, 4'hF, 4'h7, 0, 1);
    chk(got_err == 1'b1, "R8", "error on last write beat", got_err, 1);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_dw_cnt = 1;
    req_first_be = 0; req_last_be = 0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_aligned_pair();
    t_unaligned_three();
    t_single_word();
    t_read_error();
    t_read_unaligned();
    t_full_burst();
    t_write_error_last();
    chk(overlap == 0, "R10", "address offered while response pending", overlap, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule